// File: doc/BRIEF.md
# Locked Clock Policy Controller

This block is the register front end of a clock control unit. It keeps one mask register for each power policy; bit `c` of a mask enables clock `c` whenever that policy is in force. A policy select input chooses which policy drives the per-clock enable outputs.

Software reaches the block through a simple register bus. Writes are refused until a key has been written to the access register at offset 0. The mask tables are double-buffered. Software edits a staged copy, and it may do so only after it has halted the policy engine with a configuration-enable bit. A restart command then copies the staged tables into the active tables that drive the enables. There are two restart flavours. The fast one completes in one cycle and the slow one completes in three.

Top module: `ccp_policy_ctrl`

## Requirements
- R1: After reset the block is locked, the error flag is 0, configuration-enable is 0, the restart busy bit is 0, and every staged and active mask holds all ones, so `clk_en` is all ones.
- R2: A write to offset 0x00 whose bits [31:8] equal 0xA5A5A5 sets the lock state from bit 0 (1 = unlocked, 0 = locked). A read of offset 0x00 returns the unlocked state in bit 0 and the error flag in bit 1.
- R3: While locked, a write to any offset other than 0x00 is dropped and sets the sticky error flag. A write to offset 0x00 with a wrong key also sets the flag and leaves the lock state alone. Only a write with the correct key and bit 1 = 1 clears the flag.
- R4: The staged mask for policy p sits at offset 0x10 + 4·p, and bit c belongs to clock c. A write to it takes effect only while configuration-enable (offset 0x04, bit 0) is 1; otherwise the write is ignored.
- R5: `clk_en` equals the active mask of the policy named by `pol_sel`. It follows a change of `pol_sel` within the same cycle.
- R6: Changes to a staged mask do not reach `clk_en` until a restart completes.
- R7: A write to offset 0x08 with bit 0 (go) set, together with bit 2 (fast) or bit 1 (slow), is accepted as a restart and clears configuration-enable. A go without either restart bit is ignored.
- R8: A fast restart loads the active masks at the first clock edge after the accepting edge. A slow restart loads them at the third edge. If both bits are set, the restart is fast. Offset 0x08 bit 0 reads 1 from acceptance until the load and 0 afterwards.
- R9: While a restart is in progress, writes to offsets 0x04 and 0x08 are ignored.
- R10: Reads are combinational from `bus_addr`. Unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pol_sel | input | 2 | Policy in force |
| clk_en | output | 16 | Per-clock enables of the selected policy |

## Verification
Register writes become visible one edge after the cycle in which the strobe is high. A read of the same offset in the following cycle therefore shows the result. `clk_en` responds to `pol_sel` without any edge. After a restart is accepted, the active masks change one edge later for the fast flavour and three edges later for the slow one, and the busy bit falls at that same edge. The bench advances a behavioural model at every rising edge, holding the pending load as a count of remaining edges. It compares both `bus_rdata` and `clk_en` at every falling edge, so any result that appears one cycle early or late is reported.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam logic [23:0] ACC_KEY     = 24'hA5A5A5;
  localparam int unsigned OFS_ACCESS  = 0;
  localparam int unsigned OFS_CONFIG  = 4;
  localparam int unsigned OFS_CONTROL = 8;
  localparam int unsigned OFS_MASK0   = 16;
  localparam int unsigned BIT_GO      = 0;
  localparam int unsigned BIT_SLOW    = 1;
  localparam int unsigned BIT_FAST    = 2;

  typedef enum logic [1:0] {
    REST_NONE = 2'd0,
    REST_SLOW = 2'd1,
    REST_FAST = 2'd2
  } restart_e;
endpackage

// File: rtl/ccp_access_lock.sv
module ccp_access_lock #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [23:0]       key_in,
  input  logic [1:0]        ctl_in,
  output logic              unlocked,
  output logic              err,
  output logic              wr_ok
);
  import ccp_pkg::*;

  logic acc_hit, key_ok;
  logic unl_d, unl_q, err_d, err_q, unl_ce, err_ce;

  assign acc_hit = bus_we && (bus_addr == ADDR_W'(OFS_ACCESS));
  assign key_ok  = (key_in == ACC_KEY);

  always_comb begin
    unl_d = unl_q;
    err_d = err_q;
    if (acc_hit) begin
      if (key_ok) begin
        unl_d = ctl_in[0];
        if (ctl_in[1]) err_d = 1'b0;
      end else begin
        err_d = 1'b1;
      end
    end else if (bus_we && !unl_q) begin
      err_d = 1'b1;
    end
  end

  assign unl_ce = acc_hit && key_ok;
  assign err_ce = bus_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unl_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (unl_ce) unl_q <= unl_d;
      if (err_ce) err_q <= err_d;
    end
  end

  assign unlocked = unl_q;
  assign err      = err_q;
  assign wr_ok    = bus_we && !acc_hit && unl_q;
endmodule

// File: rtl/ccp_engine.sv
module ccp_engine #(
  parameter int ADDR_W   = 8,
  parameter int SLOW_LAT = 3,
  parameter int FAST_LAT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [2:0]        cmd_in,
  output logic              cfg_en,
  output logic              busy,
  output logic              load
);
  import ccp_pkg::*;

  localparam int MAX_LAT = (SLOW_LAT > FAST_LAT) ? SLOW_LAT : FAST_LAT;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  restart_e         kind;
  logic             cfg_hit, ctl_hit;
  logic             cfg_d, cfg_q, busy_d, busy_q;
  logic [CNT_W-1:0] cnt_d, cnt_q;

  assign cfg_hit = wr_ok && (bus_addr == ADDR_W'(OFS_CONFIG));
  assign ctl_hit = wr_ok && (bus_addr == ADDR_W'(OFS_CONTROL));

  always_comb begin
    kind = REST_NONE;
    if (cmd_in[BIT_GO]) begin
      if (cmd_in[BIT_FAST])      kind = REST_FAST;
      else if (cmd_in[BIT_SLOW]) kind = REST_SLOW;
    end
  end

  assign load = busy_q && (cnt_q == CNT_W'(1));

  always_comb begin
    cfg_d  = cfg_q;
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (busy_q) begin
      cnt_d = cnt_q - CNT_W'(1);
      if (load) busy_d = 1'b0;
    end else if (ctl_hit && (kind != REST_NONE)) begin
      busy_d = 1'b1;
      cnt_d  = (kind == REST_FAST) ? CNT_W'(FAST_LAT) : CNT_W'(SLOW_LAT);
      cfg_d  = 1'b0;
    end else if (cfg_hit) begin
      cfg_d = cmd_in[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cfg_q  <= cfg_d;
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign cfg_en = cfg_q;
  assign busy   = busy_q;
endmodule

// File: rtl/ccp_mask_bank.sv
module ccp_mask_bank #(
  parameter int                 ADDR_W   = 8,
  parameter int                 NUM_CLK  = 16,
  parameter int                 NUM_POL  = 4,
  parameter logic [NUM_CLK-1:0] MASK_RST = '1,
  localparam int                POL_W    = (NUM_POL > 1) ? $clog2(NUM_POL) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_ok,
  input  logic               cfg_en,
  input  logic               load,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [NUM_CLK-1:0] mask_in,
  input  logic [POL_W-1:0]   pol_sel,
  output logic               rd_hit,
  output logic [NUM_CLK-1:0] rd_data,
  output logic [NUM_CLK-1:0] clk_en
);
  import ccp_pkg::*;

  localparam int FLAT_W = NUM_CLK * NUM_POL;

  logic [NUM_POL-1:0] hit;
  logic [FLAT_W-1:0]  stg_flat, act_flat;

  for (genvar p = 0; p < NUM_POL; p++) begin : g_pol
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(OFS_MASK0 + 4 * p);
    logic               stg_ce;
    logic [NUM_CLK-1:0] stg_q, act_q;

    assign hit[p]  = (bus_addr == MY_ADDR);
    assign stg_ce  = wr_ok && cfg_en && hit[p];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_q <= MASK_RST;
        act_q <= MASK_RST;
      end else begin
        if (stg_ce) stg_q <= mask_in;
        if (load)   act_q <= stg_q;
      end
    end

    assign stg_flat[p*NUM_CLK +: NUM_CLK] = stg_q;
    assign act_flat[p*NUM_CLK +: NUM_CLK] = act_q;
  end

  always_comb begin
    rd_data = '0;
    clk_en  = '0;
    for (int p = 0; p < NUM_POL; p++) begin
      if (hit[p])                 rd_data = stg_flat[p*NUM_CLK +: NUM_CLK];
      if (pol_sel == POL_W'(p))   clk_en  = act_flat[p*NUM_CLK +: NUM_CLK];
    end
  end

  assign rd_hit = |hit;
endmodule

// File: rtl/ccp_policy_ctrl.sv
module ccp_policy_ctrl #(
  parameter int                 ADDR_W   = 8,
  parameter int                 NUM_CLK  = 16,
  parameter int                 NUM_POL  = 4,
  parameter int                 SLOW_LAT = 3,
  parameter int                 FAST_LAT = 1,
  parameter logic [NUM_CLK-1:0] MASK_RST = '1,
  localparam int                POL_W    = (NUM_POL > 1) ? $clog2(NUM_POL) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [POL_W-1:0]   pol_sel,
  output logic [NUM_CLK-1:0] clk_en
);
  import ccp_pkg::*;

  logic               unlocked, err, wr_ok;
  logic               cfg_en, busy, load;
  logic               mask_hit;
  logic [NUM_CLK-1:0] mask_rd;
  logic               unused_wdata;

  assign unused_wdata = ^bus_wdata;

  ccp_access_lock #(.ADDR_W(ADDR_W)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .key_in   (bus_wdata[31:8]),
    .ctl_in   (bus_wdata[1:0]),
    .unlocked (unlocked),
    .err      (err),
    .wr_ok    (wr_ok)
  );

  ccp_engine #(
    .ADDR_W   (ADDR_W),
    .SLOW_LAT (SLOW_LAT),
    .FAST_LAT (FAST_LAT)
  ) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ok    (wr_ok),
    .bus_addr (bus_addr),
    .cmd_in   (bus_wdata[2:0]),
    .cfg_en   (cfg_en),
    .busy     (busy),
    .load     (load)
  );

  ccp_mask_bank #(
    .ADDR_W   (ADDR_W),
    .NUM_CLK  (NUM_CLK),
    .NUM_POL  (NUM_POL),
    .MASK_RST (MASK_RST)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ok    (wr_ok),
    .cfg_en   (cfg_en),
    .load     (load),
    .bus_addr (bus_addr),
    .mask_in  (bus_wdata[NUM_CLK-1:0]),
    .pol_sel  (pol_sel),
    .rd_hit   (mask_hit),
    .rd_data  (mask_rd),
    .clk_en   (clk_en)
  );

  // R10: combinational read mux, zero for unmapped offsets
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_ACCESS))       bus_rdata = {30'b0, err, unlocked};
    else if (bus_addr == ADDR_W'(OFS_CONFIG))  bus_rdata = {31'b0, cfg_en};
    else if (bus_addr == ADDR_W'(OFS_CONTROL)) bus_rdata = {31'b0, busy};
    else if (mask_hit)                         bus_rdata = 32'(mask_rd);
  end
endmodule

// File: rtl/ccp_policy_ctrl_sva.sv
module ccp_policy_ctrl_sva #(
  parameter int ADDR_W  = 8,
  parameter int NUM_CLK = 16,
  parameter int POL_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_we,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [31:0]        bus_wdata,
  input logic [POL_W-1:0]   pol_sel,
  input logic [NUM_CLK-1:0] clk_en,
  input logic               unlocked,
  input logic               err,
  input logic               cfg_en,
  input logic               busy,
  input logic               load
);
  import ccp_pkg::*;

  a_r2_lock_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(unlocked) |->
      $past(bus_we && (bus_addr == ADDR_W'(OFS_ACCESS)) && (bus_wdata[31:8] == ACC_KEY)));

  a_r3_locked_write_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_addr != ADDR_W'(OFS_ACCESS)) && !unlocked) |=> err);

  a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !(bus_we && (bus_addr == ADDR_W'(OFS_ACCESS)) &&
              (bus_wdata[31:8] == ACC_KEY) && bus_wdata[1])) |=> err);

  a_r6_enables_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(pol_sel) && !$past(load)) |-> $stable(clk_en));

  a_r7_accept_stops_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !cfg_en);

  a_r8_busy_ends_at_load: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(load));

  a_r9_cfg_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> $stable(cfg_en));
endmodule

bind ccp_policy_ctrl ccp_policy_ctrl_sva #(
  .ADDR_W  (ADDR_W),
  .NUM_CLK (NUM_CLK),
  .POL_W   (POL_W)
) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pol_sel   (pol_sel),
  .clk_en    (clk_en),
  .unlocked  (unlocked),
  .err       (err),
  .cfg_en    (cfg_en),
  .busy      (busy),
  .load      (load)
);

// File: tb/ccp_policy_ctrl_test.sv
module ccp_policy_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [1:0]  pol_sel = 2'd0;
  logic [15:0] clk_en;

  int checks = 0;
  int fails  = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  ccp_policy_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pol_sel(pol_sel),
    .clk_en(clk_en)
  );

  // behavioural reference model
  bit          m_unl, m_err, m_cfg, m_busy;
  int          m_left;
  logic [15:0] m_stg [4];
  logic [15:0] m_act [4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_unl = 0; m_err = 0; m_cfg = 0; m_busy = 0; m_left = 0;
      for (int i = 0; i < 4; i++) begin m_stg[i] = 16'hFFFF; m_act[i] = 16'hFFFF; end
    end else begin
      bit was_busy, was_cfg, was_unl;
      was_busy = m_busy; was_cfg = m_cfg; was_unl = m_unl;
      if (was_busy) begin
        m_left--;
        if (m_left == 0) begin
          for (int i = 0; i < 4; i++) m_act[i] = m_stg[i];
          m_busy = 0;
        end
      end
      if (bus_we) begin
        if (bus_addr == 8'h00) begin
          if (bus_wdata[31:8] == 24'hA5A5A5) begin
            m_unl = bus_wdata[0];
            if (bus_wdata[1]) m_err = 0;
          end else m_err = 1;
        end else if (!was_unl) begin
          m_err = 1;
        end else if (bus_addr == 8'h04) begin
          if (!was_busy) m_cfg = bus_wdata[0];
        end else if (bus_addr == 8'h08) begin
          if (!was_busy && bus_wdata[0] && (bus_wdata[1] || bus_wdata[2])) begin
            m_busy = 1; m_cfg = 0;
            m_left = bus_wdata[2] ? 1 : 3;
          end
        end else if (bus_addr >= 8'h10 && bus_addr <= 8'h1C && bus_addr[1:0] == 2'b00) begin
          if (was_cfg) m_stg[(bus_addr - 8'h10) >> 2] = bus_wdata[15:0];
        end
      end
    end
  end

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    if (a == 8'h00) return {30'b0, m_err, m_unl};
    if (a == 8'h04) return {31'b0, m_cfg};
    if (a == 8'h08) return {31'b0, m_busy};
    if (a >= 8'h10 && a <= 8'h1C && a[1:0] == 2'b00) return {16'b0, m_stg[(a - 8'h10) >> 2]};
    return 32'h0; // R10 unmapped
  endfunction

  task automatic compare();
    logic [31:0] er;
    logic [15:0] ee;
    er = exp_rd(bus_addr);
    ee = rst_n ? m_act[pol_sel] : 16'hFFFF;
    checks++;
    if (bus_rdata !== er) begin
      fails++;
      $display("FAIL %s rdata addr=%h actual=%h expected=%h", tag, bus_addr, bus_rdata, er);
    end
    checks++;
    if (clk_en !== ee) begin
      fails++;
      $display("FAIL %s clk_en pol=%0d actual=%h expected=%h", tag, pol_sel, clk_en, ee);
    end
  endtask

  task automatic step(input logic we, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    compare();
    bus_we = we; bus_addr = a; bus_wdata = d;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(1'b1, a, d);
  endtask

  task automatic rd(input logic [7:0] a);
    step(1'b0, a, 32'h0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int unsigned lf;
    // R1: reset state
    tag = "R1";
    repeat (2) rd(8'h00);
    @(negedge clk); rst_n = 1'b1;
    rd(8'h00); rd(8'h04); rd(8'h08);
    for (int p = 0; p < 4; p++) begin pol_sel = 2'(p); rd(8'h10 + 8'(4 * p)); end

    // R3: locked writes dropped and flagged
    tag = "R3";
    wr(8'h04, 32'h1); rd(8'h04); rd(8'h00);
    wr(8'h00, 32'h1234_5603); rd(8'h00);
    wr(8'h00, 32'hA5A5_A501); rd(8'h00);   // unlock, flag stays
    // R2: key with clear, then relock
    tag = "R2";
    wr(8'h00, 32'hA5A5_A503); rd(8'h00);
    wr(8'h00, 32'hA5A5_A500); rd(8'h00);
    tag = "R3";
    wr(8'h10, 32'h0000_1111); rd(8'h10); rd(8'h00);
    tag = "R2";
    wr(8'h00, 32'hA5A5_A503); rd(8'h00);

    // R4: mask write while running is ignored
    tag = "R4";
    wr(8'h14, 32'h0000_00F0); rd(8'h14);
    wr(8'h04, 32'h1); rd(8'h04);
    wr(8'h10, 32'h0000_0001); wr(8'h14, 32'h0000_0F0F);
    wr(8'h18, 32'h0000_A5A5); wr(8'h1C, 32'h0000_8000);
    rd(8'h10); rd(8'h14); rd(8'h18); rd(8'h1C);

    // R6 / R5: enables still from the old tables while pol_sel moves
    tag = "R6";
    for (int p = 0; p < 4; p++) begin pol_sel = 2'(p); rd(8'h0C); end

    // R7: go without restart flavour is ignored
    tag = "R7";
    wr(8'h08, 32'h1); rd(8'h08); rd(8'h04);
    // R8: fast restart
    tag = "R8";
    pol_sel = 2'd2;
    wr(8'h08, 32'h5); rd(8'h08); rd(8'h08); rd(8'h04);
    tag = "R5";
    for (int p = 0; p < 4; p++) begin pol_sel = 2'(p); rd(8'h10 + 8'(4 * p)); end

    // R8: slow restart with R9 writes during busy
    tag = "R8";
    wr(8'h04, 32'h1); wr(8'h14, 32'h0000_3C3C);
    pol_sel = 2'd1;
    wr(8'h08, 32'h3);
    tag = "R9";
    wr(8'h04, 32'h1); wr(8'h08, 32'h5);
    rd(8'h08); rd(8'h08); rd(8'h04); rd(8'h14);
    // R8: both flavours set means fast
    tag = "R8";
    wr(8'h04, 32'h1); wr(8'h1C, 32'h0000_0042);
    pol_sel = 2'd3;
    wr(8'h08, 32'h7); rd(8'h08); rd(8'h08);

    // R10: unmapped reads
    tag = "R10";
    rd(8'h0C); rd(8'hFC); rd(8'h20);

    // mixed pseudo-random traffic
    tag = "R4";
    lf = 32'h1BAD_5EED;
    for (int n = 0; n < 600; n++) begin
      logic [7:0]  a;
      logic [31:0] d;
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
      case (lf[3:0])
        4'd0, 4'd1: a = 8'h00;
        4'd2, 4'd3: a = 8'h04;
        4'd4, 4'd5: a = 8'h08;
        4'd6:       a = 8'h0C;
        default:    a = 8'h10 + {4'b0, lf[5:4], 2'b00};
      endcase
      d = {lf[31:16], lf[15:8] ^ lf[23:16], lf[7:0]};
      if (a == 8'h00) d[31:8] = (lf[8:6] == 3'd0) ? 24'h123456 : 24'hA5A5A5;
      if (a == 8'h00 && lf[9]) d[0] = 1'b1;
      if (a == 8'h08) d = {29'b0, lf[12:10] | 3'b001};
      pol_sel = lf[15:14];
      step(lf[20] | lf[21], a, d);
    end
    rd(8'h00);
    summary();
    $finish;
  end
endmodule